// File: doc/BRIEF.md
# System Control Register Bank

A 4 KiB memory-mapped window of 32-bit control and status words, accessed over a plain single-cycle bus. A request strobe together with a write enable either stores a full word or starts a read. Read data appears on the following clock. The word is selected by the byte address shifted right by two, so the two low address bits have no effect.

One control word doubles as a command port. Writing the value 1 or 2 to byte offset 0xF00 produces a one-clock system-reset request pulse. Writing the value 3 there produces a one-clock shutdown request pulse. Any other value at that offset only updates storage. Three status offsets always read back with bits 29 and 28 forced high. The stored contents at those offsets are not changed. Four identification words leave reset holding fixed values, and every other word leaves reset at zero.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, reads at byte offsets 0x104, 0x000, 0x110 and 0xF00 return 0x00000002, 0, 0 and 0. Words 0x40, 0x42 and 0x43 (byte offsets 0x100, 0x108, 0x10C) hold 0x05F20121, 0x05F30121 and 0x05F40121.
- R2: A write (req=1, we=1) stores all 32 bits of wdata in word addr[11:2]. A later read of that word returns the stored value.
- R3: Address bits 1:0 are ignored for both reads and writes.
- R4: A write of 1 or 2 to offset 0xF00 drives rst_req high for exactly the one cycle after the write edge, and the value is stored.
- R5: A write of 3 to offset 0xF00 drives off_req high for exactly the one cycle after the write edge, and the value is stored.
- R6: A write of any other value to 0xF00, or of any value to another offset, raises neither request and only updates storage.
- R7: A read at offset 0x100, 0x108 or 0x10C returns the stored word OR 0x30000000. A read at any other offset returns the stored word unchanged.
- R8: While rst_n is low, rst_req, off_req and rdata stay 0 and bus writes are not stored.
- R9: rdata is updated only by a read request. It holds its value across writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Bus request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after a read request |
| rst_req | output | 1 | One-cycle system reset request |
| off_req | output | 1 | One-cycle shutdown request |

## Verification
Corrupted storage, such as a wrong reset image, a dropped write or an aliased index, shows up on rdata on the cycle after the first read of the affected word. A wrong command decode shows up one cycle after the write, as a missing, doubled or wrong request pulse. A read mask applied at the wrong offset shows on the next read of that offset, or of its unmasked neighbour 0x104. The sequence therefore reads back every word it touches and checks the request pins after every cycle.

// File: rtl/sysctl_pkg.sv
// Shared constants for the system control register bank: command and
// status word indices, forced status bits and the reset image.
package sysctl_pkg;

    localparam int unsigned MAP_IDX_W = 10;

    // Word index of the command register (byte offset 0xF00).
    localparam logic [MAP_IDX_W-1:0] CMD_IDX = 10'h3C0;

    // Command values recognised at the command register.
    localparam logic [31:0] CMD_RESET_A = 32'd1;
    localparam logic [31:0] CMD_RESET_B = 32'd2;
    localparam logic [31:0] CMD_OFF     = 32'd3;

    // Status words read with forced bits (byte offsets 0x100, 0x108, 0x10C).
    localparam int unsigned N_STATUS = 3;
    localparam logic [MAP_IDX_W-1:0] STATUS_IDX [N_STATUS] = '{10'h040, 10'h042, 10'h043};
    localparam logic [31:0] STATUS_FORCE = 32'h3000_0000;

    // Reset value of a word, computed from its index.
    function automatic logic [31:0] reset_word(input int unsigned idx);
        case (idx)
            32'h40:  return 32'h05F2_0121;
            32'h41:  return 32'h0000_0002;
            32'h42:  return 32'h05F3_0121;
            32'h43:  return 32'h05F4_0121;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Address decoder: turns the word index into command and status hits.
// Assumes the caller has already dropped the byte-lane address bits.
module sysctl_decode
    import sysctl_pkg::*;
#(
    parameter int unsigned IDX_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    output logic             cmd_hit,
    output logic             status_hit
);

    logic [N_STATUS-1:0] hit_vec;

    // One comparator per status word.
    for (genvar k = 0; k < N_STATUS; k++) begin : g_status
        assign hit_vec[k] = (idx == IDX_W'(STATUS_IDX[k]));
    end

    // Combine the hits.
    always_comb begin
        cmd_hit    = (idx == IDX_W'(CMD_IDX));
        status_hit = |hit_vec;
    end

endmodule

// File: rtl/sysctl_store.sv
// Word storage covering the whole window. It loads the reset image on a
// synchronous active-low reset and takes full-word writes. The read port
// is combinational; the top registers it.
module sysctl_store
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 1024,
    localparam int unsigned IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem [WORDS];

    // Load the reset image, or store the full written word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= DATA_W'(reset_word(i));
            end
        end else if (wr_en) begin
            mem[idx] <= wdata;
        end
    end

    // Present the addressed word.
    always_comb rd_word = mem[idx];

    // R2: the written word is present at its index after the write edge.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/sysctl_cmd.sv
// Command decoder for the command register. It turns a qualifying write
// into a one-cycle request pulse, registered one cycle after the write.
// Assumes the write strobe and hit are qualified by the caller.
module sysctl_cmd
    import sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              cmd_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic              rst_req,
    output logic              off_req
);

    logic is_reset_val;
    logic is_off_val;

    // Classify the written value.
    always_comb begin
        is_reset_val = (wdata == DATA_W'(CMD_RESET_A)) || (wdata == DATA_W'(CMD_RESET_B));
        is_off_val   = (wdata == DATA_W'(CMD_OFF));
    end

    // Register the request pulses; both are held low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            off_req <= 1'b0;
        end else begin
            rst_req <= wr_en && cmd_hit && is_reset_val;
            off_req <= wr_en && cmd_hit && is_off_val;
        end
    end

    // R4: a reset request follows only a command write.
    a_r4_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(wr_en && cmd_hit));

    // R5: a shutdown request follows only a command write of 3.
    a_r5_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
        off_req |-> $past(wr_en && cmd_hit && (wdata == DATA_W'(CMD_OFF))));

    // R6: the two requests never fire together.
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && off_req));

endmodule

// File: rtl/sysctl_regbank.sv
// System control register bank top. It joins decode, storage and command
// logic, and registers read data with the status bits forced at the
// status offsets. Assumes single-cycle requests with word-aligned intent;
// address bits 1:0 are dropped.
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req,
    output logic              off_req
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned WORDS = 1 << IDX_W;

    logic [IDX_W-1:0]  idx;
    logic [1:0]        lane_unused;
    logic              wr_en;
    logic              rd_en;
    logic              cmd_hit;
    logic              status_hit;
    logic [DATA_W-1:0] rd_word;

    // Split the address and qualify the strobes.
    always_comb begin
        idx         = addr[ADDR_W-1:2];
        lane_unused = addr[1:0];
        wr_en       = req && we;
        rd_en       = req && !we;
    end

    sysctl_decode #(.IDX_W(IDX_W)) i_decode (
        .idx        (idx),
        .cmd_hit    (cmd_hit),
        .status_hit (status_hit)
    );

    sysctl_store #(.DATA_W(DATA_W), .WORDS(WORDS)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (idx),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    sysctl_cmd #(.DATA_W(DATA_W)) i_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .cmd_hit (cmd_hit),
        .wdata   (wdata),
        .rst_req (rst_req),
        .off_req (off_req)
    );

    // Register read data, with status bits forced at the status offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= status_hit ? (rd_word | DATA_W'(STATUS_FORCE)) : rd_word;
        end
    end

    // R7: a status read returns bits 29:28 set.
    a_r7_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && status_hit) |=> (rdata[29:28] == 2'b11));

    // R9: without a read request, read data holds.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    // R8: outputs are quiet on the edge after reset is sampled.
    a_r8_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!rst_req && !off_req && (rdata == '0)));

endmodule

// File: tb/test_sysctl_regbank.sv
`timescale 1ns/1ps
module test_sysctl_regbank;

    typedef struct {
        logic [31:0] rd;
        logic        rq;
        logic        off;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;
    logic        off_req;

    int          vectors = 0;
    int          errs = 0;
    bit          done = 1'b0;
    exp_t        q[$];
    logic [31:0] model [1024];
    logic [31:0] last_rd = '0;

    always #4 clk = ~clk;

    sysctl_regbank i_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .off_req(off_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic is_status(input logic [9:0] w);
        return (w == 10'h40) || (w == 10'h42) || (w == 10'h43);
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        model[a[11:2]] = d;
        e.rd  = last_rd;
        e.rq  = (a[11:2] == 10'h3C0) && (d == 32'd1 || d == 32'd2);
        e.off = (a[11:2] == 10'h3C0) && (d == 32'd3);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic bus_read(input logic [11:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a; wdata = 32'hDEAD_BEEF;
        last_rd = model[a[11:2]] | (is_status(a[11:2]) ? 32'h3000_0000 : 32'h0);
        e.rd = last_rd; e.rq = 1'b0; e.off = 1'b0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        req = 1'b0; we = 1'b1; addr = 12'hF00; wdata = 32'd1;
        e.rd = last_rd; e.rq = 1'b0; e.off = 1'b0; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops one expected item per clock, sampled 2 ns after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " rdata"}, rdata, e.rd);
                check({e.tag, " rst_req"}, {31'b0, rst_req}, {31'b0, e.rq});
                check({e.tag, " off_req"}, {31'b0, off_req}, {31'b0, e.off});
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        if (!done) begin
            errs++;
            vectors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = 32'h0;
        model[10'h40] = 32'h05F2_0121;
        model[10'h41] = 32'h0000_0002;
        model[10'h42] = 32'h05F3_0121;
        model[10'h43] = 32'h05F4_0121;

        // R8: reset held with a command write on the bus.
        req = 1'b1; we = 1'b1; addr = 12'hF00; wdata = 32'd1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); #2;
            check("R8 rst_req in reset", {31'b0, rst_req}, 32'd0);
            check("R8 off_req in reset", {31'b0, off_req}, 32'd0);
            check("R8 rdata in reset", rdata, 32'd0);
        end
        @(negedge clk);
        rst_n = 1'b1; req = 1'b0;

        // R1 and R7: reset image and forced status bits.
        bus_read(12'h100, "R1 R7 word40");
        bus_read(12'h104, "R1 word41 unmasked");
        bus_read(12'h108, "R1 R7 word42");
        bus_read(12'h10C, "R1 R7 word43");
        bus_read(12'h110, "R1 word44 zero");
        bus_read(12'h000, "R1 word0 zero");
        bus_read(12'hF00, "R8 write in reset dropped");

        // R2: full-word store.
        bus_write(12'h200, 32'hA5A5_1234, "R2 write");
        bus_read(12'h200, "R2 readback");
        bus_write(12'h7F0, 32'hFFFF_FFFF, "R2 write ones");
        bus_read(12'h7F0, "R2 readback ones");

        // R3: byte-lane bits ignored.
        bus_write(12'h3FE, 32'h1357_9BDF, "R3 write lane2");
        bus_read(12'h3FD, "R3 read lane1");
        bus_read(12'h3FC, "R3 read lane0");

        // R7: masking does not change storage, neighbours unmasked.
        bus_write(12'h100, 32'h0, "R7 clear status");
        bus_read(12'h100, "R7 forced bits on zero");
        bus_write(12'h104, 32'h0, "R7 clear neighbour");
        bus_read(12'h104, "R7 neighbour unmasked");
        bus_write(12'h10C, 32'hC000_0001, "R7 write status");
        bus_read(12'h10F, "R7 forced OR stored");

        // R4 and R5: command pulses.
        bus_write(12'hF00, 32'd1, "R4 cmd 1");
        idle("R4 pulse ends");
        bus_write(12'hF00, 32'd2, "R4 cmd 2");
        bus_read(12'hF00, "R4 stored 2");
        bus_write(12'hF00, 32'd3, "R5 cmd 3");
        idle("R5 pulse ends");
        bus_read(12'hF00, "R5 stored 3");
        bus_write(12'hF00, 32'd1, "R4 back to back a");
        bus_write(12'hF00, 32'd3, "R5 back to back b");
        bus_write(12'hF03, 32'd3, "R3 R5 cmd via lane3");

        // R6: other values and other offsets.
        bus_write(12'hF00, 32'd4, "R6 cmd 4");
        bus_read(12'hF00, "R6 stored 4");
        bus_write(12'hF00, 32'h1_0001, "R6 high bits set");
        bus_write(12'hF04, 32'd1, "R6 other offset 1");
        bus_write(12'hF04, 32'd3, "R6 other offset 3");
        bus_write(12'h000, 32'd2, "R6 offset 0 value 2");
        bus_read(12'hF04, "R6 stored at F04");

        // R9: hold across idle and writes.
        bus_read(12'h200, "R9 load");
        idle("R9 hold idle");
        idle("R9 hold idle 2");
        bus_write(12'h200, 32'h0BAD_F00D, "R9 hold across write");
        bus_read(12'h200, "R9 new value");
        idle("drain");
        idle("drain");

        wait (q.size() == 0);
        @(posedge clk); #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule